// File: doc/BRIEF.md
# FIFO Fill-Level Tracker with Threshold Interrupts

This block counts the entries in a transmit queue and a receive queue that share one fixed byte budget. The entry capacity of each queue follows the selected word width: a narrower word leaves room for more entries. The bus side and the serial engine send push and pop strobes. The block keeps both occupancy counts, raises a transmit request and a receive request from two 2-bit threshold modes, and packs the counts and flags into a 32-bit status word. It holds no data and does no shifting. Both of those belong to the neighbouring logic.

Each queue is tracked by an occupancy state machine with three states: `OCC_EMPTY`, `OCC_PARTIAL` and `OCC_FULL`. It has these transitions:
- **fill**: `OCC_EMPTY` to `OCC_PARTIAL` on an accepted push.
- **top-up**: `OCC_PARTIAL` to `OCC_FULL` when a push reaches capacity.
- **release**: `OCC_FULL` to `OCC_PARTIAL` on a pop.
- **drain**: `OCC_PARTIAL` to `OCC_EMPTY` when a pop reaches zero.
- **flush**: any state to `OCC_EMPTY` when the width selection changes.

A push that the receive queue rejects sets a sticky overflow flag. That flag drives the error request only while its enable is high.

Top module: `fifo_lvl_irq`

## Requirements
- R1: Capacity in entries is 16 for `width_sel`=0 (8-bit words), 8 for `width_sel`=1 (16-bit) and 4 for `width_sel`=2 or 3 (32-bit). A level never exceeds the capacity.
- R2: `rx_irq` follows `rx_mode`. Mode 0 means the level is zero. Mode 1 means the level is nonzero. Mode 2 means the level is at least half the capacity. Mode 3 means the level equals the capacity.
- R3: `tx_irq` follows `tx_mode`. Mode 0 means the level is zero and `shifter_busy` is low. Mode 1 means the level is zero. Mode 2 means free slots are at least half the capacity. Mode 3 means at least one slot is free.
- R4: The status word carries the transmit level in bits 20:16 and the receive level in bits 28:24. Bit 5 is high when the receive level is zero. Bit 6 is the receive overflow flag. All other bits are zero.
- R5: A push into a full queue that has no pop in the same cycle leaves the level unchanged. On the receive side it also sets the sticky overflow flag, which stays set until `ovf_clr` is pulsed. A rejected transmit push sets no flag.
- R6: A pop from an empty queue leaves the level at zero.
- R7: When a push and a pop arrive together, a nonzero level stays unchanged and no overflow is raised, even at full. At zero the push is accepted and the level becomes 1.
- R8: `err_irq` is high exactly when the overflow flag is set and `ovf_irq_en` is high.
- R9: Any change of `width_sel` clears both levels on the next edge. Strobes in that cycle are discarded.
- R10: The interrupt lines are combinational in the levels, the modes and `shifter_busy`. A mode change shows on the line in the same cycle.
- R11: After reset both levels are zero and the overflow flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| width_sel | input | 2 | Word width: 0=8, 1=16, 2/3=32 bits |
| rx_mode | input | 2 | Receive threshold mode |
| tx_mode | input | 2 | Transmit threshold mode |
| ovf_irq_en | input | 1 | Enables the error request |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| tx_push | input | 1 | Bus side writes a transmit entry |
| tx_pop | input | 1 | Serial engine takes a transmit entry |
| rx_push | input | 1 | Serial engine stores a receive entry |
| rx_pop | input | 1 | Bus side reads a receive entry |
| shifter_busy | input | 1 | Serial shifter still holds a word |
| tx_irq | output | 1 | Transmit threshold request |
| rx_irq | output | 1 | Receive threshold request |
| err_irq | output | 1 | Gated receive overflow request |
| status | output | 32 | Packed levels and flags |

## Verification
The bench drives the receive queue to each threshold boundary at 8-bit width: one entry, half, one short of full, and full. A design with an off-by-one half-point or full compare would flip `rx_irq` one entry early or late. It pushes into a full receive queue and pops an empty one. A counter that wraps would show a level of 0 or 31 instead of holding. It also checks that only the receive side raises the sticky flag. It changes the width with a push in the same cycle, and then fills at 16-bit and 32-bit widths. A stale capacity or a leaked strobe would leave a nonzero level or a count past 8 or 4. Simultaneous push and pop at full and at empty expose designs that reject the push before the pop frees a slot, or that accept a pop from nothing.

// File: rtl/fifo_lvl_pkg.sv
package fifo_lvl_pkg;

    // Occupancy state of one queue
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_e;

    // Word width selection codes
    localparam logic [1:0] WS_BYTE = 2'd0;
    localparam logic [1:0] WS_HALF = 2'd1;

    // Threshold mode codes
    localparam logic [1:0] TM_0 = 2'd0;
    localparam logic [1:0] TM_1 = 2'd1;
    localparam logic [1:0] TM_2 = 2'd2;
    localparam logic [1:0] TM_3 = 2'd3;

    // Right shift applied to the byte budget for a given width code
    function automatic int unsigned width_shift(input logic [1:0] ws);
        if (ws == WS_BYTE)
            return 0;
        else if (ws == WS_HALF)
            return 1;
        else
            return 2;
    endfunction

endpackage

// File: rtl/fifo_width_ctl.sv
module fifo_width_ctl
    import fifo_lvl_pkg::*;
#(
    parameter int FIFO_BYTES = 16,
    localparam int LVL_W = $clog2(FIFO_BYTES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       width_sel,
    output logic             flush,
    output logic [LVL_W-1:0] cap
);

    logic [1:0] width_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            width_q <= WS_BYTE;
        else
            width_q <= width_sel;
    end

    always_comb begin
        flush = (width_sel != width_q);
        cap   = LVL_W'(FIFO_BYTES >> width_shift(width_q));
    end

endmodule

// File: rtl/fifo_lvl_track.sv
module fifo_lvl_track
    import fifo_lvl_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [LVL_W-1:0] cap,
    input  logic             push,
    input  logic             pop,
    output logic [LVL_W-1:0] level,
    output logic             is_empty,
    output logic             is_full,
    output logic             push_drop
);

    occ_e             st_q, st_d;
    logic [LVL_W-1:0] lvl_q, lvl_d;
    logic             pop_ok, push_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= OCC_EMPTY;
            lvl_q <= '0;
        end else begin
            st_q  <= st_d;
            lvl_q <= lvl_d;
        end
    end

    // next state: fill, top-up, release, drain, flush
    always_comb begin
        pop_ok  = pop && (st_q != OCC_EMPTY) && !flush;
        push_ok = push && !flush && ((st_q != OCC_FULL) || pop_ok);
        lvl_d   = lvl_q;
        st_d    = st_q;
        if (flush) begin
            lvl_d = '0;
            st_d  = OCC_EMPTY;
        end else begin
            unique case ({push_ok, pop_ok})
                2'b10:   lvl_d = lvl_q + 1'b1;
                2'b01:   lvl_d = lvl_q - 1'b1;
                default: lvl_d = lvl_q;
            endcase
            unique case (st_q)
                OCC_EMPTY:   if (lvl_d != '0) st_d = (lvl_d == cap) ? OCC_FULL : OCC_PARTIAL;
                OCC_PARTIAL: if (lvl_d == '0) st_d = OCC_EMPTY;
                             else if (lvl_d == cap) st_d = OCC_FULL;
                OCC_FULL:    if (lvl_d != cap) st_d = (lvl_d == '0) ? OCC_EMPTY : OCC_PARTIAL;
                default:     st_d = OCC_EMPTY;
            endcase
        end
    end

    // outputs
    always_comb begin
        level     = lvl_q;
        is_empty  = 1'b0;
        is_full   = 1'b0;
        push_drop = push && !push_ok && !flush;
        unique case (st_q)
            OCC_EMPTY: is_empty = 1'b1;
            OCC_FULL:  is_full  = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/fifo_thr_irq.sv
module fifo_thr_irq
    import fifo_lvl_pkg::*;
#(
    parameter int LVL_W = 5,
    parameter bit IS_TX = 1'b0
) (
    input  logic [1:0]       mode,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] cap,
    input  logic             idle,
    output logic             irq
);

    logic [LVL_W-1:0] half;
    assign half = cap >> 1;

    generate
        if (IS_TX) begin : g_tx
            logic [LVL_W-1:0] free;
            assign free = cap - level;
            always_comb begin
                unique case (mode)
                    TM_0:    irq = (level == '0) && idle;
                    TM_1:    irq = (level == '0);
                    TM_2:    irq = (free >= half);
                    default: irq = (level != cap);
                endcase
            end
        end else begin : g_rx
            always_comb begin
                unique case (mode)
                    TM_0:    irq = (level == '0);
                    TM_1:    irq = (level != '0);
                    TM_2:    irq = (level >= half);
                    default: irq = (level == cap);
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/fifo_lvl_irq.sv
module fifo_lvl_irq
    import fifo_lvl_pkg::*;
#(
    parameter int FIFO_BYTES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  width_sel,
    input  logic [1:0]  rx_mode,
    input  logic [1:0]  tx_mode,
    input  logic        ovf_irq_en,
    input  logic        ovf_clr,
    input  logic        tx_push,
    input  logic        tx_pop,
    input  logic        rx_push,
    input  logic        rx_pop,
    input  logic        shifter_busy,
    output logic        tx_irq,
    output logic        rx_irq,
    output logic        err_irq,
    output logic [31:0] status
);

    localparam int LVL_W   = $clog2(FIFO_BYTES) + 1;
    localparam int TXL_LSB = 16;
    localparam int RXL_LSB = 24;
    localparam int RXE_BIT = 5;
    localparam int OVF_BIT = 6;

    logic             flush;
    logic [LVL_W-1:0] cap;
    logic [LVL_W-1:0] tx_lvl, rx_lvl;
    logic             tx_empty, tx_full, tx_drop;
    logic             rx_empty, rx_full, rx_drop;
    logic             ovf_q;

    fifo_width_ctl #(.FIFO_BYTES(FIFO_BYTES)) u_width (
        .clk(clk), .rst_n(rst_n), .width_sel(width_sel),
        .flush(flush), .cap(cap)
    );

    fifo_lvl_track #(.LVL_W(LVL_W)) u_tx_trk (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap),
        .push(tx_push), .pop(tx_pop), .level(tx_lvl),
        .is_empty(tx_empty), .is_full(tx_full), .push_drop(tx_drop)
    );

    fifo_lvl_track #(.LVL_W(LVL_W)) u_rx_trk (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap),
        .push(rx_push), .pop(rx_pop), .level(rx_lvl),
        .is_empty(rx_empty), .is_full(rx_full), .push_drop(rx_drop)
    );

    fifo_thr_irq #(.LVL_W(LVL_W), .IS_TX(1'b1)) u_tx_thr (
        .mode(tx_mode), .level(tx_lvl), .cap(cap),
        .idle(!shifter_busy), .irq(tx_irq)
    );

    fifo_thr_irq #(.LVL_W(LVL_W), .IS_TX(1'b0)) u_rx_thr (
        .mode(rx_mode), .level(rx_lvl), .cap(cap),
        .idle(1'b1), .irq(rx_irq)
    );

    // sticky receive overflow; a new overflow wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (rx_drop)
            ovf_q <= 1'b1;
        else if (ovf_clr)
            ovf_q <= 1'b0;
    end

    always_comb begin
        err_irq = ovf_q && ovf_irq_en;
        status  = '0;
        status[TXL_LSB +: LVL_W] = tx_lvl;
        status[RXL_LSB +: LVL_W] = rx_lvl;
        status[RXE_BIT]          = rx_empty;
        status[OVF_BIT]          = ovf_q;
    end

    logic unused_ok;
    assign unused_ok = ^{tx_empty, tx_full, tx_drop, rx_full};

endmodule

// File: rtl/fifo_lvl_irq_chk.sv
module fifo_lvl_irq_chk #(
    parameter int FIFO_BYTES = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  width_sel,
    input logic [1:0]  rx_mode,
    input logic        ovf_irq_en,
    input logic        ovf_clr,
    input logic        rx_push,
    input logic        rx_pop,
    input logic        rx_irq,
    input logic        err_irq,
    input logic [31:0] status
);

    logic [1:0] w_prev;
    logic       chg;
    logic [4:0] cap_c, rx_l, tx_l;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_prev <= 2'd0;
        else        w_prev <= width_sel;
    end

    assign chg   = (width_sel != w_prev);
    assign cap_c = (w_prev == 2'd0) ? 5'(FIFO_BYTES) :
                   (w_prev == 2'd1) ? 5'(FIFO_BYTES / 2) : 5'(FIFO_BYTES / 4);
    assign rx_l  = status[28:24];
    assign tx_l  = status[20:16];

    // R1
    lvl_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_l <= cap_c) && (tx_l <= cap_c));

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (rx_l == 5'd0) && (tx_l == 5'd0));

    // R5
    full_push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg && rx_push && !rx_pop && rx_l == cap_c) |=> ($stable(rx_l) && status[6]));

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6] && !ovf_clr) |=> status[6]);

    // R6
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg && rx_pop && !rx_push && rx_l == 5'd0) |=> (rx_l == 5'd0));

    // R8
    err_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_irq_en |-> !err_irq);

    // R2
    rx_full_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_mode == 2'd3) |-> (rx_irq == (rx_l == cap_c)));

endmodule

bind fifo_lvl_irq fifo_lvl_irq_chk #(.FIFO_BYTES(FIFO_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .rx_mode(rx_mode),
    .ovf_irq_en(ovf_irq_en), .ovf_clr(ovf_clr), .rx_push(rx_push),
    .rx_pop(rx_pop), .rx_irq(rx_irq), .err_irq(err_irq), .status(status)
);

// File: tb/fifo_lvl_irq_bench.sv
module fifo_lvl_irq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  width_sel = 2'd0, rx_mode = 2'd0, tx_mode = 2'd0;
    logic        ovf_irq_en = 1'b0, ovf_clr = 1'b0;
    logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic        shifter_busy = 1'b0;
    logic        tx_irq, rx_irq, err_irq;
    logic [31:0] status;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    fifo_lvl_irq u_fifo_lvl_irq (
        .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .rx_mode(rx_mode),
        .tx_mode(tx_mode), .ovf_irq_en(ovf_irq_en), .ovf_clr(ovf_clr),
        .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
        .shifter_busy(shifter_busy), .tx_irq(tx_irq), .rx_irq(rx_irq),
        .err_irq(err_irq), .status(status)
    );

    function automatic logic [31:0] mk(input int rxl, input int txl, input bit ovf);
        logic [31:0] s = '0;
        s[28:24] = 5'(rxl);
        s[20:16] = 5'(txl);
        s[5]     = (rxl == 0);
        s[6]     = ovf;
        return s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one strobe cycle: set at a falling edge, captured at the next rising edge
    task automatic pulse(input bit tp, input bit to, input bit rp, input bit ro, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tx_push = tp; tx_pop = to; rx_push = rp; rx_pop = ro;
            @(negedge clk);
            tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
        end
    endtask

    task automatic set_width(input logic [1:0] w, input bit with_push);
        @(negedge clk);
        width_sel = w; rx_push = with_push; tx_push = with_push;
        @(negedge clk);
        rx_push = 0; tx_push = 0;
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R11 status", status, mk(0, 0, 0));
        check("R4 empty bit", 32'(status[5]), 32'd1);
        check("R2 rx mode0", 32'(rx_irq), 32'd1);
        check("R3 tx mode0", 32'(tx_irq), 32'd1);
        check("R11 err", 32'(err_irq), 32'd0);
    endtask

    task automatic t_rx_thresholds;
        rx_mode = 2'd1; #1;
        check("R2 mode1 empty", 32'(rx_irq), 32'd0);
        pulse(0, 0, 1, 0, 1);
        check("R2 mode1 one", 32'(rx_irq), 32'd1);
        check("R4 rx level 1", status, mk(1, 0, 0));
        rx_mode = 2'd2; #1;
        check("R10 mode change", 32'(rx_irq), 32'd0);
        pulse(0, 0, 1, 0, 7);
        check("R2 mode2 half", 32'(rx_irq), 32'd1);
        rx_mode = 2'd3; #1;
        pulse(0, 0, 1, 0, 7);
        check("R2 mode3 15", 32'(rx_irq), 32'd0);
        pulse(0, 0, 1, 0, 1);
        check("R1 rx full 16", 32'(rx_irq), 32'd1);
        pulse(0, 0, 1, 0, 1);
        check("R5 rx overflow", status, mk(16, 0, 1));
        check("R8 err gated", 32'(err_irq), 32'd0);
        ovf_irq_en = 1'b1; #1;
        check("R8 err enabled", 32'(err_irq), 32'd1);
        @(negedge clk) ovf_clr = 1'b1;
        @(negedge clk) ovf_clr = 1'b0;
        check("R5 clear", status, mk(16, 0, 0));
        check("R8 err cleared", 32'(err_irq), 32'd0);
    endtask

    task automatic t_rx_pop;
        pulse(0, 0, 0, 1, 16);
        pulse(0, 0, 0, 1, 1);
        check("R6 pop empty", status, mk(0, 0, 0));
        rx_mode = 2'd0; #1;
        check("R2 mode0 empty", 32'(rx_irq), 32'd1);
    endtask

    task automatic t_tx_modes;
        shifter_busy = 1'b1; tx_mode = 2'd0; #1;
        check("R3 mode0 busy", 32'(tx_irq), 32'd0);
        shifter_busy = 1'b0; #1;
        check("R10 busy drop", 32'(tx_irq), 32'd1);
        pulse(1, 0, 0, 0, 1);
        check("R3 mode0 one", 32'(tx_irq), 32'd0);
        tx_mode = 2'd1; #1;
        check("R3 mode1 one", 32'(tx_irq), 32'd0);
        tx_mode = 2'd3; #1;
        check("R3 mode3 one", 32'(tx_irq), 32'd1);
        tx_mode = 2'd2; #1;
        pulse(1, 0, 0, 0, 7);
        check("R3 mode2 8", 32'(tx_irq), 32'd1);
        pulse(1, 0, 0, 0, 1);
        check("R3 mode2 9", 32'(tx_irq), 32'd0);
        tx_mode = 2'd3;
        pulse(1, 0, 0, 0, 7);
        check("R3 mode3 full", 32'(tx_irq), 32'd0);
        pulse(1, 0, 0, 0, 1);
        check("R5 tx full push", status, mk(0, 16, 0));
    endtask

    task automatic t_width;
        set_width(2'd1, 1'b1);
        check("R9 flush to 16b", status, mk(0, 0, 0));
        pulse(1, 0, 0, 0, 9);
        check("R1 tx cap 8", status, mk(0, 8, 0));
        rx_mode = 2'd3;
        pulse(0, 0, 1, 0, 8);
        check("R1 rx full 8", 32'(rx_irq), 32'd1);
        set_width(2'd2, 1'b0);
        check("R9 flush to 32b", status, mk(0, 0, 0));
        pulse(0, 0, 1, 0, 5);
        check("R1 rx cap 4", status, mk(4, 0, 1));
        @(negedge clk) ovf_clr = 1'b1;
        @(negedge clk) ovf_clr = 1'b0;
        set_width(2'd3, 1'b0);
        check("R9 flush 2->3", status, mk(0, 0, 0));
        pulse(0, 0, 1, 0, 4);
        check("R1 code3 cap 4", 32'(rx_irq), 32'd1);
    endtask

    task automatic t_simul;
        pulse(0, 0, 1, 1, 1);
        check("R7 full push+pop", status, mk(4, 0, 0));
        pulse(0, 0, 0, 1, 4);
        pulse(0, 0, 1, 1, 1);
        check("R7 empty push+pop", status, mk(1, 0, 0));
    endtask

    initial begin
        t_reset();
        t_rx_thresholds();
        t_rx_pop();
        t_tx_modes();
        t_width();
        t_simul();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule